// File: doc/BRIEF.md
# Adjacent Memory Access Fuser

This block sits between an in-order queue of memory micro-ops and a single load/store pipe whose data path is 128 bits wide. It keeps the oldest operation in a one-entry holding slot and compares it against the next operation offered on the input. When both are loads, or both are stores, and they have the same size and register class, it merges them into one access of twice the width. The second address must follow the first without a gap, and the merged access must be naturally aligned. The merged access carries both destination tags. For stores, the two data words are packed into one wide word.

When memory returns the data for a load, the response path splits it again. The lower half goes to the operation at the lower address and the upper half goes to the other one. Software sees two ordinary loads. Operations that cannot be merged leave one per cycle in program order. A free-running counter reports how many merges have been issued.

Sizes are encoded as 0 = 32 bits, 1 = 64 bits and 2 = 128 bits. Addresses are byte addresses. Data words are little-endian: byte 0 is bits 7:0.

Top module: `lsb_bond_unit`

## Requirements
- R1: After a synchronous reset the block is idle: `out_valid`, `wb_lo_valid` and `wb_hi_valid` are 0, `fuse_count` is 0 and `in_ready` is 1.
- R2: A load and a store are never merged, even when their addresses are adjacent and aligned.
- R3: A merge requires the second operation's address to equal the first operation's address plus the first operation's byte size (4, 8 or 16). A pair in reverse order, or with a gap between them, issues as two separate accesses.
- R4: Two adjacent 32-bit integer operations (size 0, `in_fp`=0) leave as one access with `out_size`=1, `out_fused`=1 and the first operation's address.
- R5: Two adjacent 64-bit integer operations (size 1) leave as one access with `out_size`=2 and `out_fused`=1.
- R6: Two adjacent 64-bit floating-point operations (`in_fp`=1, size 1) leave as one 128-bit access with `out_fp`=1. A floating-point pair of 32-bit operations, and any pair of 128-bit operations, is never merged.
- R7: Operations that differ in size, or in class (integer versus floating point), are never merged.
- R8: A merge happens only when the first address is a multiple of the merged width: 8 bytes for a 64-bit result, 16 bytes for a 128-bit result. Otherwise both operations issue unmerged.
- R9: Output store data is zero above the access width. A merged store carries the first operation's data in the lower half and the second operation's data in the upper half. An unmerged access carries `out_tag_hi`=0.
- R10: One cycle after a response, `wb_lo_valid` is 1 with `wb_lo_tag`=`rsp_tag_lo` and the low op-width bits of `rsp_data`. When `rsp_fused`=1, `wb_hi_valid` is also 1, with `wb_hi_tag`=`rsp_tag_hi` and the next op-width bits of `rsp_data`. `rsp_size` gives the size of each original operation.
- R11: Unmerged operations leave in input order. The held operation issues alone when no following operation is being offered. While `out_valid`=1 and `out_ready`=0, all output fields hold their values.
- R12: `fuse_count` rises by exactly one for each merged access issued and is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operation offered |
| in_ready | output | 1 | Input operation accepted this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_fp | input | 1 | 1 = floating-point class |
| in_size | input | 2 | Access size code |
| in_addr | input | ADDR_W | Byte address |
| in_tag | input | TAG_W | Destination or operation tag |
| in_wdata | input | DATA_W | Store data, low bits used |
| out_valid | output | 1 | Access presented to the pipe |
| out_ready | input | 1 | Pipe takes the access |
| out_store | output | 1 | Access is a store |
| out_fp | output | 1 | Access is floating-point class |
| out_size | output | 2 | Size code of the issued access |
| out_addr | output | ADDR_W | Access byte address |
| out_wdata | output | DATA_W | Packed store data |
| out_fused | output | 1 | Access combines two operations |
| out_tag_lo | output | TAG_W | Tag of the lower-address operation |
| out_tag_hi | output | TAG_W | Tag of the upper-address operation |
| rsp_valid | input | 1 | Load data returned |
| rsp_size | input | 2 | Size code of each original operation |
| rsp_fused | input | 1 | Response belongs to a merged load |
| rsp_tag_lo | input | TAG_W | Echoed lower tag |
| rsp_tag_hi | input | TAG_W | Echoed upper tag |
| rsp_data | input | DATA_W | Returned data |
| wb_lo_valid | output | 1 | Writeback for lower operation |
| wb_lo_tag | output | TAG_W | Lower writeback tag |
| wb_lo_data | output | DATA_W | Lower writeback data |
| wb_hi_valid | output | 1 | Writeback for upper operation |
| wb_hi_tag | output | TAG_W | Upper writeback tag |
| wb_hi_data | output | DATA_W | Upper writeback data |
| fuse_count | output | CNT_W | Number of merges issued |

## Verification
The assertions check on every cycle that a merged access is aligned and never narrower than 64 bits, that a merged floating-point access is 128 bits, and that the output holds while stalled. They also check that the counter moves only by one, and only together with a newly loaded merged access, and that a response always produces a lower writeback one cycle later, with the upper one only alongside it. Only the bench's scenarios can show which pairs are actually merged and which are refused. This includes the reversed, gapped, misaligned, mixed-kind and mixed-class pairs. The scenarios also cover the order of unmerged operations, the packing of store data, and the split of returned load data into the right tags.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } lsb_size_e;

  function automatic int op_bits(input logic [1:0] s);
    case (s)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/lsb_pair_check.sv
module lsb_pair_check #(
  parameter int ADDR_W = 32
) (
  input  logic              a_store,
  input  logic              a_fp,
  input  logic [1:0]        a_size,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_store,
  input  logic              b_fp,
  input  logic [1:0]        b_size,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              can_bond
);
  import lsb_pkg::*;

  logic [ADDR_W-1:0] step;
  logic same_kind, size_ok, adjacent, aligned;

  always_comb begin
    case (a_size)
      SZ_32:   step = ADDR_W'(4);
      SZ_64:   step = ADDR_W'(8);
      default: step = ADDR_W'(16);
    endcase
    same_kind = (a_store == b_store) && (a_fp == b_fp) && (a_size == b_size);
    size_ok   = a_fp ? (a_size == SZ_64) : (a_size == SZ_32 || a_size == SZ_64);
    adjacent  = (b_addr == a_addr + step);
    aligned   = (a_size == SZ_32) ? (a_addr[2:0] == 3'd0) : (a_addr[3:0] == 4'd0);
    can_bond  = same_kind && size_ok && adjacent && aligned;
  end
endmodule

// File: rtl/lsb_issue_stage.sv
module lsb_issue_stage #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_store,
  input  logic              in_fp,
  input  logic [1:0]        in_size,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_store,
  output logic              out_fp,
  output logic [1:0]        out_size,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata,
  output logic              out_fused,
  output logic [TAG_W-1:0]  out_tag_lo,
  output logic [TAG_W-1:0]  out_tag_hi,
  output logic [CNT_W-1:0]  fuse_count
);
  import lsb_pkg::*;

  logic              slot_v, slot_store, slot_fp;
  logic [1:0]        slot_size;
  logic [ADDR_W-1:0] slot_addr;
  logic [TAG_W-1:0]  slot_tag;
  logic [DATA_W-1:0] slot_wdata;

  logic can_bond, advance, emit, bond_now, take_in;
  logic [DATA_W-1:0] half_mask, packed_data;
  int half_bits;

  lsb_pair_check #(.ADDR_W(ADDR_W)) pair_i (
    .a_store(slot_store), .a_fp(slot_fp), .a_size(slot_size), .a_addr(slot_addr),
    .b_store(in_store),   .b_fp(in_fp),   .b_size(in_size),   .b_addr(in_addr),
    .can_bond(can_bond)
  );

  always_comb begin
    advance   = !out_valid || out_ready;
    emit      = advance && slot_v;
    bond_now  = emit && in_valid && can_bond;
    in_ready  = !slot_v || advance;
    take_in   = in_valid && in_ready;
    half_bits = op_bits(slot_size);
    half_mask = {DATA_W{1'b1}} >> (DATA_W - half_bits);
    if (bond_now)
      packed_data = ((in_wdata & half_mask) << half_bits) | (slot_wdata & half_mask);
    else
      packed_data = slot_wdata & half_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v     <= 1'b0;
      slot_store <= 1'b0;
      slot_fp    <= 1'b0;
      slot_size  <= 2'd0;
      slot_addr  <= '0;
      slot_tag   <= '0;
      slot_wdata <= '0;
    end else if (take_in && !bond_now) begin
      slot_v     <= 1'b1;
      slot_store <= in_store;
      slot_fp    <= in_fp;
      slot_size  <= in_size;
      slot_addr  <= in_addr;
      slot_tag   <= in_tag;
      slot_wdata <= in_wdata;
    end else if (emit) begin
      slot_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_store  <= 1'b0;
      out_fp     <= 1'b0;
      out_size   <= 2'd0;
      out_addr   <= '0;
      out_wdata  <= '0;
      out_fused  <= 1'b0;
      out_tag_lo <= '0;
      out_tag_hi <= '0;
      fuse_count <= '0;
    end else begin
      if (advance) out_valid <= emit;
      if (emit) begin
        out_store  <= slot_store;
        out_fp     <= slot_fp;
        out_size   <= bond_now ? slot_size + 2'd1 : slot_size;
        out_addr   <= slot_addr;
        out_wdata  <= packed_data;
        out_fused  <= bond_now;
        out_tag_lo <= slot_tag;
        out_tag_hi <= bond_now ? in_tag : '0;
      end
      if (bond_now) fuse_count <= fuse_count + CNT_W'(1);
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_size)
      && $stable(out_fused) && $stable(out_wdata) && $stable(out_tag_lo)));

  // R8
  fused_align_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fused) |->
      ((out_size == SZ_64) ? (out_addr[2:0] == 3'd0) : (out_addr[3:0] == 4'd0)));

  // R6
  fused_width_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fused) |-> (out_size != SZ_32 && !(out_fp && out_size != SZ_128)));

  // R12
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fuse_count != $past(fuse_count)) |->
      (out_valid && out_fused && fuse_count == $past(fuse_count) + CNT_W'(1)));
endmodule

// File: rtl/lsb_resp_split.sv
module lsb_resp_split #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_size,
  input  logic              rsp_fused,
  input  logic [TAG_W-1:0]  rsp_tag_lo,
  input  logic [TAG_W-1:0]  rsp_tag_hi,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wb_lo_valid,
  output logic [TAG_W-1:0]  wb_lo_tag,
  output logic [DATA_W-1:0] wb_lo_data,
  output logic              wb_hi_valid,
  output logic [TAG_W-1:0]  wb_hi_tag,
  output logic [DATA_W-1:0] wb_hi_data
);
  import lsb_pkg::*;

  int op_w;
  logic [DATA_W-1:0] op_mask;

  always_comb begin
    op_w    = op_bits(rsp_size);
    op_mask = {DATA_W{1'b1}} >> (DATA_W - op_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_lo_valid <= 1'b0;
      wb_hi_valid <= 1'b0;
      wb_lo_tag   <= '0;
      wb_hi_tag   <= '0;
      wb_lo_data  <= '0;
      wb_hi_data  <= '0;
    end else begin
      wb_lo_valid <= rsp_valid;
      wb_hi_valid <= rsp_valid && rsp_fused;
      if (rsp_valid) begin
        wb_lo_tag  <= rsp_tag_lo;
        wb_lo_data <= rsp_data & op_mask;
        wb_hi_tag  <= rsp_tag_hi;
        wb_hi_data <= (rsp_data >> op_w) & op_mask;
      end
    end
  end

  // R10
  hi_with_lo_chk: assert property (@(posedge clk) disable iff (rst)
    wb_hi_valid |-> wb_lo_valid);

  // R10
  wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> wb_lo_valid);
endmodule

// File: rtl/lsb_bond_unit.sv
module lsb_bond_unit #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_store,
  input  logic              in_fp,
  input  logic [1:0]        in_size,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_store,
  output logic              out_fp,
  output logic [1:0]        out_size,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata,
  output logic              out_fused,
  output logic [TAG_W-1:0]  out_tag_lo,
  output logic [TAG_W-1:0]  out_tag_hi,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_size,
  input  logic              rsp_fused,
  input  logic [TAG_W-1:0]  rsp_tag_lo,
  input  logic [TAG_W-1:0]  rsp_tag_hi,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              wb_lo_valid,
  output logic [TAG_W-1:0]  wb_lo_tag,
  output logic [DATA_W-1:0] wb_lo_data,
  output logic              wb_hi_valid,
  output logic [TAG_W-1:0]  wb_hi_tag,
  output logic [DATA_W-1:0] wb_hi_data,
  output logic [CNT_W-1:0]  fuse_count
);
  lsb_issue_stage #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) issue_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_store(in_store), .in_fp(in_fp),
    .in_size(in_size), .in_addr(in_addr), .in_tag(in_tag), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_store(out_store), .out_fp(out_fp),
    .out_size(out_size), .out_addr(out_addr), .out_wdata(out_wdata), .out_fused(out_fused),
    .out_tag_lo(out_tag_lo), .out_tag_hi(out_tag_hi), .fuse_count(fuse_count)
  );

  lsb_resp_split #(.TAG_W(TAG_W), .DATA_W(DATA_W)) split_i (
    .clk(clk), .rst(rst),
    .rsp_valid(rsp_valid), .rsp_size(rsp_size), .rsp_fused(rsp_fused),
    .rsp_tag_lo(rsp_tag_lo), .rsp_tag_hi(rsp_tag_hi), .rsp_data(rsp_data),
    .wb_lo_valid(wb_lo_valid), .wb_lo_tag(wb_lo_tag), .wb_lo_data(wb_lo_data),
    .wb_hi_valid(wb_hi_valid), .wb_hi_tag(wb_hi_tag), .wb_hi_data(wb_hi_data)
  );
endmodule

// File: tb/lsb_bond_unit_tb.sv
module lsb_bond_unit_tb_top;
  localparam int AW = 32, TW = 6, DW = 128, CW = 16, MAXN = 400;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic in_valid = 0, in_ready, in_store = 0, in_fp = 0;
  logic [1:0] in_size = 0;
  logic [AW-1:0] in_addr = 0;
  logic [TW-1:0] in_tag = 0;
  logic [DW-1:0] in_wdata = 0;
  logic out_valid, out_ready = 0, out_store, out_fp, out_fused;
  logic [1:0] out_size;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_wdata;
  logic [TW-1:0] out_tag_lo, out_tag_hi;
  logic rsp_valid = 0, rsp_fused = 0;
  logic [1:0] rsp_size = 0;
  logic [TW-1:0] rsp_tag_lo = 0, rsp_tag_hi = 0;
  logic [DW-1:0] rsp_data = 0;
  logic wb_lo_valid, wb_hi_valid;
  logic [TW-1:0] wb_lo_tag, wb_hi_tag;
  logic [DW-1:0] wb_lo_data, wb_hi_data;
  logic [CW-1:0] fuse_count;

  lsb_bond_unit #(.ADDR_W(AW), .TAG_W(TW), .DATA_W(DW), .CNT_W(CW)) dut_i (.*);

  int total = 0, bad = 0, cyc = 0, fuse_total = 0;
  bit dog = 0;

  logic op_store [MAXN], op_fp [MAXN];
  logic [1:0] op_size [MAXN];
  logic [AW-1:0] op_addr [MAXN];
  logic [TW-1:0] op_tag [MAXN];
  logic [DW-1:0] op_data [MAXN];
  int n_ops;

  logic x_store [MAXN], x_fp [MAXN], x_fused [MAXN];
  logic [1:0] x_size [MAXN];
  logic [AW-1:0] x_addr [MAXN];
  logic [TW-1:0] x_lo [MAXN], x_hi [MAXN];
  logic [DW-1:0] x_data [MAXN];
  int n_exp;

  function automatic logic [DW-1:0] keep(input logic [1:0] s);
    logic [DW-1:0] m = '1;
    return m >> (DW - (32 << s));
  endfunction

  function automatic bit pairable(input int a, input int b);
    int nb = 4 << op_size[a];
    if (op_store[a] != op_store[b] || op_fp[a] != op_fp[b] || op_size[a] != op_size[b]) return 0;
    if (op_size[a] == 2'd2) return 0;
    if (op_fp[a] && op_size[a] != 2'd1) return 0;
    if (op_addr[b] != op_addr[a] + 32'(nb)) return 0;
    if ((op_addr[a] % (2 * nb)) != 0) return 0;
    return 1;
  endfunction

  function automatic void build_exp();
    int i = 0;
    n_exp = 0;
    while (i < n_ops) begin
      x_store[n_exp] = op_store[i]; x_fp[n_exp] = op_fp[i]; x_addr[n_exp] = op_addr[i];
      x_lo[n_exp] = op_tag[i];
      if (i + 1 < n_ops && pairable(i, i + 1)) begin
        x_fused[n_exp] = 1; x_size[n_exp] = op_size[i] + 2'd1; x_hi[n_exp] = op_tag[i+1];
        x_data[n_exp] = ((op_data[i+1] & keep(op_size[i])) << (32 << op_size[i]))
                        | (op_data[i] & keep(op_size[i]));
        fuse_total++; i += 2;
      end else begin
        x_fused[n_exp] = 0; x_size[n_exp] = op_size[i]; x_hi[n_exp] = '0;
        x_data[n_exp] = op_data[i] & keep(op_size[i]);
        i += 1;
      end
      n_exp++;
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic add_op(input logic st, input logic fp, input logic [1:0] sz, input logic [AW-1:0] a);
    op_store[n_ops] = st; op_fp[n_ops] = fp; op_size[n_ops] = sz; op_addr[n_ops] = a;
    op_tag[n_ops] = TW'(n_ops + 1); op_data[n_ops] = rnd128();
    n_ops++;
  endtask

  task automatic run_burst(input string req, input int ready_pct);
    int idx = 0, oi = 0;
    bit pend_v = 0, chk_v = 0, pend_f = 0, ef = 0;
    logic [1:0] pend_sz = 0;
    logic [TW-1:0] pend_lo = 0, pend_hi = 0, elt = 0, eht = 0;
    logic [DW-1:0] eld = 0, ehd = 0;
    build_exp();
    while ((oi < n_exp || pend_v || chk_v) && !dog) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) dog = 1;
      if (chk_v) begin
        check(wb_lo_valid && wb_lo_tag == elt && wb_lo_data == eld, "R10", "wb_lo",
              wb_lo_data, eld);
        check(wb_hi_valid == ef && (!ef || (wb_hi_tag == eht && wb_hi_data == ehd)), "R10",
              "wb_hi", wb_hi_data, ehd);
      end
      chk_v = pend_v;
      rsp_valid = pend_v;
      if (pend_v) begin
        rsp_size = pend_sz; rsp_fused = pend_f; rsp_tag_lo = pend_lo; rsp_tag_hi = pend_hi;
        rsp_data = rnd128();
        elt = pend_lo; eht = pend_hi; ef = pend_f;
        eld = rsp_data & keep(pend_sz);
        ehd = (rsp_data >> (32 << pend_sz)) & keep(pend_sz);
      end
      pend_v = 0;
      out_ready = (($urandom % 100) < ready_pct);
      in_valid = (idx < n_ops);
      if (idx < n_ops) begin
        in_store = op_store[idx]; in_fp = op_fp[idx]; in_size = op_size[idx];
        in_addr = op_addr[idx]; in_tag = op_tag[idx]; in_wdata = op_data[idx];
      end
      #1;
      if (out_valid && out_ready) begin
        if (oi < n_exp) begin
          check(out_store == x_store[oi] && out_fp == x_fp[oi] && out_size == x_size[oi]
                && out_addr == x_addr[oi] && out_fused == x_fused[oi]
                && out_tag_lo == x_lo[oi] && out_tag_hi == x_hi[oi], req, "access",
                {out_fused, out_size, out_addr}, {x_fused[oi], x_size[oi], x_addr[oi]});
          if (out_store) check(out_wdata == x_data[oi], "R9", "wdata", out_wdata, x_data[oi]);
          if (!out_store) begin
            pend_v = 1; pend_f = out_fused; pend_lo = out_tag_lo; pend_hi = out_tag_hi;
            pend_sz = out_fused ? out_size - 2'd1 : out_size;
          end
        end else check(0, req, "extra output", out_addr, 0);
        oi++;
      end
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 0; rsp_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    if (dog) check(0, req, "watchdog", cyc, 0);
    n_ops = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    n_ops = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1
    check(!out_valid && !wb_lo_valid && !wb_hi_valid && fuse_count == 0 && in_ready, "R1",
          "reset", {out_valid, wb_lo_valid, wb_hi_valid, in_ready}, 4'b0001);

    add_op(0, 0, 0, 32'h100); add_op(0, 0, 0, 32'h104); run_burst("R4", 100);
    add_op(1, 0, 1, 32'h200); add_op(1, 0, 1, 32'h208); run_burst("R5", 60);
    add_op(0, 1, 1, 32'h300); add_op(0, 1, 1, 32'h308); run_burst("R6", 100);
    add_op(0, 1, 0, 32'h310); add_op(0, 1, 0, 32'h314); run_burst("R6", 100);
    add_op(0, 0, 2, 32'h400); add_op(0, 0, 2, 32'h410); run_burst("R6", 100);
    add_op(0, 0, 0, 32'h104); add_op(0, 0, 0, 32'h108); run_burst("R8", 100);
    add_op(0, 0, 1, 32'h508); add_op(0, 0, 1, 32'h510); run_burst("R8", 100);
    add_op(0, 0, 0, 32'h600); add_op(1, 0, 0, 32'h604); run_burst("R2", 100);
    add_op(0, 0, 1, 32'h700); add_op(0, 1, 1, 32'h708); run_burst("R7", 100);
    add_op(0, 0, 0, 32'h800); add_op(0, 0, 1, 32'h804); run_burst("R7", 100);
    add_op(0, 0, 0, 32'h908); add_op(0, 0, 0, 32'h900); run_burst("R3", 100);
    add_op(0, 0, 0, 32'hA00); add_op(0, 0, 0, 32'hA08); run_burst("R3", 100);
    add_op(1, 0, 0, 32'hB00); add_op(1, 0, 0, 32'hB04); run_burst("R9", 50);
    // R11: operations offered apart never merge
    add_op(0, 0, 0, 32'hC00); run_burst("R11", 100);
    add_op(0, 0, 0, 32'hC04); run_burst("R11", 100);

    // random mix, stalls on the output side (R11)
    for (int k = 0; k < 300; k++) begin
      logic st, fp;
      logic [1:0] sz;
      logic [AW-1:0] a;
      if (k > 0 && ($urandom % 4) != 0) begin
        st = op_store[k-1]; fp = op_fp[k-1]; sz = op_size[k-1];
        a = op_addr[k-1] + 32'(4 << sz);
      end else begin
        st = $urandom % 2; fp = ($urandom % 4) == 0;
        sz = fp ? ((($urandom % 4) == 0) ? 2'd0 : 2'd1) : 2'($urandom % 3);
        a = ($urandom % 32'h1000) & ~32'((4 << sz) - 1);
      end
      add_op(st, fp, sz, a);
    end
    run_burst("R11", 70);

    @(negedge clk);
    // R12
    check(fuse_count == CW'(fuse_total), "R12", "fuse_count", fuse_count, fuse_total);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule